// File: doc/BRIEF.md
# Serial Bus Status Flag Register

This block keeps three sticky status flags for a two-wire serial bus controller. One flag marks a stop condition that arrived while a frame was still moving (error stop). One marks a stop condition that arrived after a frame had finished (normal stop). One marks that a data-register-empty or data-register-full event fired, which asks for a continuous-transfer interrupt. The bus engine sends single-cycle event pulses and a mode select. The block decodes these into set and clear events for each flag. It also owns the shared interrupt flag, which goes high together with the transfer flag.

Software sees the flags through a byte-wide read/write port. Each flag is a small state machine with three named states. `FLG_IDLE` means the flag is 0. `FLG_SET` means the flag is 1 but has not yet been read as 1. `FLG_ARMED` means the flag is 1 and has been read as 1. The transitions are:
- **raise**: a set event moves IDLE to SET.
- **observe**: a read moves SET to ARMED.
- **release**: a write of 0 to the flag's bit moves ARMED to IDLE.
- **flush**: a clear of the shared flag moves SET or ARMED to IDLE.

A set event in the same cycle as a release or a flush holds the flag at 1.

Top module: `bus_stat_flags`

## Requirements
- R1: After reset, all three flags, `irq_flag` and `rd_data` are 0.
- R2: In mode 2'b00 (slave, bus format), `stop_det` with `frame_busy`=1 sets `err_stop` at the next clock edge.
- R3: In mode 2'b00, `stop_det` with `frame_busy`=0 sets `norm_stop` at the next clock edge.
- R4: In modes 2'b01 (master), 2'b10 (clocked synchronous) and 2'b11 (reserved), `stop_det` sets no flag.
- R5: In mode 2'b00, `xfer_evt` sets `xfer_irq` only when `addr_match` is 1.
- R6: In modes 2'b01 and 2'b10, `xfer_evt` sets `xfer_irq` regardless of `addr_match`. In mode 2'b11 it never sets it.
- R7: `irq_flag` sets at the same edge that sets `xfer_irq`. A pulse on `irq_clr` clears it unless the transfer flag is being set in that cycle.
- R8: `rd_data` always shows the flags: bit 7 is `err_stop`, bit 6 is `norm_stop`, bit 5 is `xfer_irq`, and bits 4..0 read as 0.
- R9: A flag clears when a write carries 0 in the flag's bit and that flag was read as 1 by an earlier `rd_en` cycle. Without that earlier read, a write of 0 leaves the flag set.
- R10: Writing 1 to a flag bit has no effect on that flag.
- R11: `irq_clr` clears `err_stop` and `norm_stop` in any state. It clears `xfer_irq` only while `if_en` is 1.
- R12: A set event in the same cycle as a clearing write or an `irq_clr` leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 00 slave bus format, 01 master, 10 clocked synchronous, 11 reserved |
| if_en | input | 1 | Interface enable |
| stop_det | input | 1 | Stop condition detected (pulse) |
| frame_busy | input | 1 | A frame transfer is in progress |
| xfer_evt | input | 1 | Data-register-empty or data-register-full flag set (pulse) |
| addr_match | input | 1 | Slave address matched |
| irq_clr | input | 1 | Shared interrupt flag cleared to 0 (pulse) |
| rd_en | input | 1 | Status byte read strobe |
| wr_en | input | 1 | Status byte write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Status byte |
| err_stop | output | 1 | Error stop flag |
| norm_stop | output | 1 | Normal stop flag |
| xfer_irq | output | 1 | Continuous-transfer interrupt flag |
| irq_flag | output | 1 | Shared interrupt flag |

## Verification
Raising a flag can fall in the same cycle as clearing it, either by a release write or by a clear of the shared flag. Directed steps provoke this on purpose: a transfer event is driven together with a zero write to an already-read flag, and a stop event together with `irq_clr`. Random stimulus also brings these overlaps about by chance. Each result is judged at the next falling edge against a bench model in which the set wins and the read-as-1 memory follows the flag's state.

// File: rtl/bus_stat_pkg.sv
package bus_stat_pkg;

    typedef enum logic [1:0] {
        MODE_SLV_BUS = 2'b00,
        MODE_MASTER  = 2'b01,
        MODE_CLKSYNC = 2'b10,
        MODE_RSVD    = 2'b11
    } bus_mode_e;

    typedef enum logic [1:0] {
        FLG_IDLE  = 2'b00,
        FLG_SET   = 2'b01,
        FLG_ARMED = 2'b10
    } flg_state_e;

    // flag slot indices inside set/clear vectors
    localparam int SLOT_XFER = 0;
    localparam int SLOT_NORM = 1;
    localparam int SLOT_ERR  = 2;
    localparam int SLOT_CNT  = 3;

endpackage

// File: rtl/bus_stat_set_decode.sv
module bus_stat_set_decode
    import bus_stat_pkg::*;
#(
    parameter int NUM_FLAGS = SLOT_CNT
) (
    input  logic [1:0]           mode,
    input  logic                 if_en,
    input  logic                 stop_det,
    input  logic                 frame_busy,
    input  logic                 xfer_evt,
    input  logic                 addr_match,
    input  logic                 irq_clr,
    output logic [NUM_FLAGS-1:0] set_vec,
    output logic [NUM_FLAGS-1:0] clr_vec
);

    bus_mode_e mode_e;
    logic      xfer_ok;

    assign mode_e = bus_mode_e'(mode);

    always_comb begin
        unique case (mode_e)
            MODE_SLV_BUS: xfer_ok = addr_match;
            MODE_MASTER:  xfer_ok = 1'b1;
            MODE_CLKSYNC: xfer_ok = 1'b1;
            default:      xfer_ok = 1'b0;
        endcase
    end

    always_comb begin
        set_vec            = '0;
        clr_vec            = '0;
        set_vec[SLOT_ERR]  = (mode_e == MODE_SLV_BUS) && stop_det && frame_busy;
        set_vec[SLOT_NORM] = (mode_e == MODE_SLV_BUS) && stop_det && !frame_busy;
        set_vec[SLOT_XFER] = xfer_evt && xfer_ok;
        clr_vec[SLOT_ERR]  = irq_clr;
        clr_vec[SLOT_NORM] = irq_clr;
        clr_vec[SLOT_XFER] = irq_clr && if_en;
    end

endmodule

// File: rtl/bus_stat_flag_cell.sv
module bus_stat_flag_cell
    import bus_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic rd_strobe,
    input  logic wr_zero,
    output logic flag_o
);

    flg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: begin
                if (set_evt) state_d = FLG_SET;                     // raise
            end
            FLG_SET: begin
                if (set_evt)        state_d = rd_strobe ? FLG_ARMED : FLG_SET;
                else if (clr_evt)   state_d = FLG_IDLE;             // flush
                else if (rd_strobe) state_d = FLG_ARMED;            // observe
            end
            FLG_ARMED: begin
                if (set_evt)                state_d = FLG_ARMED;
                else if (clr_evt || wr_zero) state_d = FLG_IDLE;    // flush / release
            end
            default: state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag_o = (state_q != FLG_IDLE);
    end

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_o);

    assert_zero_write_unread_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLG_SET && !clr_evt) |=> flag_o);

    assert_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !flag_o);

endmodule

// File: rtl/bus_stat_flags.sv
module bus_stat_flags
    import bus_stat_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FLAG_LO = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              if_en,
    input  logic              stop_det,
    input  logic              frame_busy,
    input  logic              xfer_evt,
    input  logic              addr_match,
    input  logic              irq_clr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_stop,
    output logic              norm_stop,
    output logic              xfer_irq,
    output logic              irq_flag
);

    localparam int NUM_FLAGS = SLOT_CNT;

    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] wr_zero;
    logic [NUM_FLAGS-1:0] flags;

    bus_stat_set_decode #(.NUM_FLAGS(NUM_FLAGS)) u_dec (
        .mode       (mode),
        .if_en      (if_en),
        .stop_det   (stop_det),
        .frame_busy (frame_busy),
        .xfer_evt   (xfer_evt),
        .addr_match (addr_match),
        .irq_clr    (irq_clr),
        .set_vec    (set_vec),
        .clr_vec    (clr_vec)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        assign wr_zero[i] = wr_en && !wr_data[FLAG_LO + i];
        bus_stat_flag_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_evt   (set_vec[i]),
            .clr_evt   (clr_vec[i]),
            .rd_strobe (rd_en),
            .wr_zero   (wr_zero[i]),
            .flag_o    (flags[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 irq_flag <= 1'b0;
        else if (set_vec[SLOT_XFER]) irq_flag <= 1'b1;
        else if (irq_clr)           irq_flag <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_FLAGS; k++) rd_data[FLAG_LO + k] = flags[k];
    end

    assign err_stop  = flags[SLOT_ERR];
    assign norm_stop = flags[SLOT_NORM];
    assign xfer_irq  = flags[SLOT_XFER];

    assert_irq_with_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_evt && (mode == 2'b01 || mode == 2'b10)) |=> (xfer_irq && irq_flag));

    assert_stop_other_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && !err_stop && !norm_stop) |=> (!err_stop && !norm_stop));

    assert_rsvd_no_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && !xfer_irq) |=> !xfer_irq);

    assert_slave_need_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !addr_match && !xfer_irq) |=> !xfer_irq);

    assert_err_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && stop_det && frame_busy) |=> err_stop);

endmodule

// File: tb/tb_bus_stat_flags.sv
`timescale 1ns/1ps
module tb_bus_stat_flags;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode;
    logic       if_en, stop_det, frame_busy, xfer_evt, addr_match, irq_clr, rd_en, wr_en;
    logic [7:0] wr_data, rd_data;
    logic       err_stop, norm_stop, xfer_irq, irq_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // model: index 2 err, 1 norm, 0 xfer
    bit [2:0] m_f = '0;
    bit [2:0] m_a = '0;
    bit       m_irq = 1'b0;

    always #10 clk = ~clk;

    bus_stat_flags dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .if_en(if_en), .stop_det(stop_det),
        .frame_busy(frame_busy), .xfer_evt(xfer_evt), .addr_match(addr_match),
        .irq_clr(irq_clr), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .err_stop(err_stop), .norm_stop(norm_stop),
        .xfer_irq(xfer_irq), .irq_flag(irq_flag)
    );

    function automatic bit [2:0] set_of(input logic [1:0] md, input logic stp, input logic bsy,
                                        input logic xev, input logic am);
        bit slv = (md == 2'b00);
        return {slv & stp & bsy, slv & stp & ~bsy,
                xev & ((slv & am) | (md == 2'b01) | (md == 2'b10))};
    endfunction

    function automatic bit [7:0] byte_of(input bit [2:0] f);
        return {f, 5'b0};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic [1:0] md, input logic en, input logic stp, input logic bsy,
                        input logic xev, input logic am, input logic iclr, input logic rd,
                        input logic wr, input logic [7:0] wd);
        bit [2:0] s, c;
        mode = md; if_en = en; stop_det = stp; frame_busy = bsy; xfer_evt = xev;
        addr_match = am; irq_clr = iclr; rd_en = rd; wr_en = wr; wr_data = wd;
        s = set_of(md, stp, bsy, xev, am);
        c = {iclr, iclr, iclr & en};
        for (int i = 0; i < 3; i++) begin
            bit wz = wr & ~wd[5 + i];
            if (s[i]) begin
                m_a[i] = m_a[i] | (rd & m_f[i]);
                m_f[i] = 1'b1;
            end else if (c[i] || (m_a[i] && wz)) begin
                m_f[i] = 1'b0; m_a[i] = 1'b0;
            end else if (m_f[i] && rd) begin
                m_a[i] = 1'b1;
            end
        end
        if (s[0]) m_irq = 1'b1;
        else if (iclr) m_irq = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R2 err_stop",  {7'b0, err_stop},  {7'b0, m_f[2]});
        chk("R3 norm_stop", {7'b0, norm_stop}, {7'b0, m_f[1]});
        chk("R6 xfer_irq",  {7'b0, xfer_irq},  {7'b0, m_f[0]});
        chk("R7 irq_flag",  {7'b0, irq_flag},  {7'b0, m_irq});
        chk("R8 rd_data",   rd_data,           byte_of(m_f));
    endtask

    task automatic idle(input logic [1:0] md);
        step(md, 1'b1, 0, 0, 0, 0, 0, 0, 0, 8'h00);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; mode = 2'b00; if_en = 1'b1; stop_det = 0; frame_busy = 0;
        xfer_evt = 0; addr_match = 0; irq_clr = 0; rd_en = 0; wr_en = 0; wr_data = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 reset rd_data", rd_data, 8'h00);
        chk("R1 reset irq", {7'b0, irq_flag}, 8'h00);
        rst_n = 1'b1;

        // R2 error stop, then R9 zero write without prior read keeps it
        step(2'b00, 1, 1, 1, 0, 0, 0, 0, 0, 8'h00);
        chk("R2 err set", {7'b0, err_stop}, 8'h01);
        step(2'b00, 1, 0, 0, 0, 0, 0, 0, 1, 8'h00);
        chk("R9 unread zero write", {7'b0, err_stop}, 8'h01);
        step(2'b00, 1, 0, 0, 0, 0, 0, 1, 0, 8'h00);
        step(2'b00, 1, 0, 0, 0, 0, 0, 0, 1, 8'h7F);
        chk("R9 read then zero write", {7'b0, err_stop}, 8'h00);

        // R3 normal stop, R11 cleared by irq_clr
        step(2'b00, 1, 1, 0, 0, 0, 0, 0, 0, 8'h00);
        chk("R3 norm set", {7'b0, norm_stop}, 8'h01);
        step(2'b00, 0, 0, 0, 0, 0, 1, 0, 0, 8'h00);
        chk("R11 norm cleared", {7'b0, norm_stop}, 8'h00);

        // R4 stop in master mode
        step(2'b01, 1, 1, 1, 0, 0, 0, 0, 0, 8'h00);
        step(2'b10, 1, 1, 0, 0, 0, 0, 0, 0, 8'h00);
        chk("R4 no stop flags", rd_data, 8'h00);

        // R6/R7 master transfer; R11 clear gated by enable
        step(2'b01, 1, 0, 0, 1, 0, 0, 0, 0, 8'h00);
        chk("R7 irq with xfer", {6'b0, xfer_irq, irq_flag}, 8'h03);
        chk("R8 byte", rd_data, 8'h20);
        step(2'b01, 0, 0, 0, 0, 0, 1, 0, 0, 8'h00);
        chk("R11 enable low keeps xfer", {6'b0, xfer_irq, irq_flag}, 8'h02);
        step(2'b01, 1, 0, 0, 0, 0, 1, 0, 0, 8'h00);
        chk("R11 enable high clears xfer", {7'b0, xfer_irq}, 8'h00);

        // R5 slave needs match
        step(2'b00, 1, 0, 0, 1, 0, 0, 0, 0, 8'h00);
        chk("R5 no match", {7'b0, xfer_irq}, 8'h00);
        step(2'b00, 1, 0, 0, 1, 1, 0, 0, 0, 8'h00);
        chk("R5 match", {7'b0, xfer_irq}, 8'h01);

        // R10 writes of 1 ignored
        step(2'b00, 1, 0, 0, 0, 0, 0, 1, 0, 8'h00);
        step(2'b00, 1, 0, 0, 0, 0, 0, 0, 1, 8'hFF);
        chk("R10 write ones", rd_data, 8'h20);

        // R12 set with clearing write, then set with irq_clr
        step(2'b00, 1, 0, 0, 1, 1, 0, 0, 1, 8'h00);
        chk("R12 set beats write", {7'b0, xfer_irq}, 8'h01);
        step(2'b00, 1, 1, 1, 0, 0, 1, 0, 0, 8'h00);
        chk("R12 set beats irq_clr", {7'b0, err_stop}, 8'h01);

        // R6 reserved mode
        step(2'b11, 1, 0, 0, 0, 0, 1, 0, 0, 8'h00);
        step(2'b11, 1, 0, 0, 1, 1, 0, 0, 0, 8'h00);
        chk("R6 reserved no xfer", {7'b0, xfer_irq}, 8'h00);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] md = 2'($urandom_range(0, 3));
            step(md, 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 7) == 0),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 5) == 0),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) == 0),
                 1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 2) == 0),
                 8'($urandom));
        end
        idle(2'b00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule